// File: doc/BRIEF.md
# Receive Task Sequencer

This block is the command engine on the receive side of a packet modem. A host writes a three-bit task code. The sequencer then runs that task against the recovered bit stream. It can hunt for a frame sync, gather a frame head, read one raw byte, or load a new sync pattern into the external correlator. Results pass through a three-byte buffer that the host reaches by byte index.

Three status flags tell the host how the task went. Buffer-free and interrupt both rise when a task finishes. An error flag reports the verdict of an external frame-head FEC checker. A mobile/base flag is captured when a sync match is found. The sequencer does not detect sync patterns itself, and it does not check frame heads itself. It drives a search enable and a pattern load to the correlator. It presents the gathered 24-bit frame head to a combinational checker, which returns a corrected data word and an uncorrectable flag. It also pulses a reinitialise line to the CRC logic.

Top module: `rx_task_seq`

## Requirements
- R1: After reset: buffer-free is 1; interrupt, error and mobile are 0; search enable is 0; the sync pattern is 0; all buffer bytes read 0.
- R2: Task codes are 0 NULL, 1 frame-head search, 2 raw three-byte read, 3 sync-only search, 4 single-byte read, 5 sync load and 7 RESET; code 6 acts as NULL. Writing any of codes 1 to 5 clears buffer-free on the next cycle. A written task replaces any task in progress.
- R3: During either search task, search enable stays high until the correlator reports a hit. For the sync-only task, a hit ends the task and latches the correlator's mobile/base polarity into the mobile flag. The buffer is left unchanged.
- R4: In a frame-head search, the 24 valid bits that follow the hit cycle form the frame head, first bit in bit 23. This frame head is presented to the checker. Corrected data bits 15:8 go to buffer index 0 and bits 7:0 to index 1. Index 2 is not changed. The error flag takes the checker's uncorrectable flag.
- R5: The raw three-byte read stores the next 24 valid bits, uncorrected, into indices 0, 1 and 2 in arrival order, first bit as bit 7 of each byte. The error flag takes the checker's flag.
- R6: The single-byte read stores the next 8 valid bits into index 0, with the earliest bit as bit 7.
- R7: The sync load sets the 16-bit pattern to {index 0, index 1}, so bit 15 is the first bit of the sync word. It pulses the pattern-load strobe for one cycle and never raises search enable.
- R8: Every task completion sets buffer-free and interrupt in the same cycle. Completion of any task other than NULL also gives a one-cycle CRC reinitialise pulse in that cycle. NULL completes on the cycle after it is written, without that pulse.
- R9: A status read clears interrupt on the next cycle. If a completion falls in the same cycle, interrupt stays set.
- R10: RESET aborts any search or read and returns to idle with search enable low and buffer-free set. It does not raise interrupt, and later bits do not alter the buffer.
- R11: Bits presented while the bit-valid input is low are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Task write strobe |
| cmd_code | input | 3 | Task code |
| stat_rd | input | 1 | Status read strobe, clears interrupt |
| st_bfree | output | 1 | Buffer-free flag |
| st_irq | output | 1 | Interrupt flag |
| st_err | output | 1 | Frame-head uncorrectable error flag |
| st_mobile | output | 1 | Mobile/base polarity flag |
| hb_wr | input | 1 | Host buffer write strobe |
| hb_idx | input | 2 | Host buffer byte index (0 to 2) |
| hb_wdata | input | 8 | Host buffer write data |
| hb_rdata | output | 8 | Buffer byte at hb_idx (0 for index 3) |
| rx_vld | input | 1 | Received bit valid |
| rx_bit | input | 1 | Received bit |
| sync_hit | input | 1 | Correlator match |
| sync_mob | input | 1 | Polarity of the bits before the match |
| sync_srch | output | 1 | Search enable to correlator |
| pat_ld | output | 1 | Pattern load strobe |
| pat | output | 16 | Sync pattern to correlator |
| fh_word | output | 24 | Gathered frame head to checker |
| fh_bad | input | 1 | Checker: uncorrectable error |
| fh_fix | input | 16 | Checker: corrected data bytes |
| crc_init | output | 1 | CRC reinitialise pulse |

## Verification
The hardest case to reach is an abort in the middle of a read. A partly filled shift register must leave no trace. The bench starts a raw read, feeds ten bits, and then writes RESET. It then streams a full frame's worth of bits and confirms that the buffer, interrupt and search enable are all untouched. A second hard case is a status read in the same cycle as the last bit of a single-byte read. The bench holds the read strobe on that bit to show that setting the interrupt wins over clearing it.

// File: rtl/rx_task_seq.sv
module rx_task_seq (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_wr,
  input  logic [2:0]  cmd_code,
  input  logic        stat_rd,
  output logic        st_bfree,
  output logic        st_irq,
  output logic        st_err,
  output logic        st_mobile,
  input  logic        hb_wr,
  input  logic [1:0]  hb_idx,
  input  logic [7:0]  hb_wdata,
  output logic [7:0]  hb_rdata,
  input  logic        rx_vld,
  input  logic        rx_bit,
  input  logic        sync_hit,
  input  logic        sync_mob,
  output logic        sync_srch,
  output logic        pat_ld,
  output logic [15:0] pat,
  output logic [23:0] fh_word,
  input  logic        fh_bad,
  input  logic [15:0] fh_fix,
  output logic        crc_init
);
  localparam logic [2:0] T_NULL = 3'd0, T_SFH = 3'd1, T_R3H = 3'd2, T_SFS = 3'd3,
                         T_RSB = 3'd4, T_LOAD = 3'd5, T_RST = 3'd7;

  typedef enum logic [2:0] {S_IDLE, S_HUNT, S_COL, S_CHK, S_LOAD} st_t;
  st_t st;
  logic [2:0]  tsk;
  logic [4:0]  cnt;
  logic [23:0] sh;
  logic [7:0]  b0, b1, b2;
  logic        last_bit;

  assign sync_srch = (st == S_HUNT);
  assign fh_word   = sh;
  assign last_bit  = (cnt == ((tsk == T_RSB) ? 5'd7 : 5'd23));

  always_comb begin
    case (hb_idx)
      2'd0:    hb_rdata = b0;
      2'd1:    hb_rdata = b1;
      2'd2:    hb_rdata = b2;
      default: hb_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; tsk <= T_NULL; cnt <= '0; sh <= '0;
      b0 <= '0; b1 <= '0; b2 <= '0;
      st_bfree <= 1'b1; st_irq <= 1'b0; st_err <= 1'b0; st_mobile <= 1'b0;
      pat <= '0; pat_ld <= 1'b0; crc_init <= 1'b0;
    end else begin
      pat_ld   <= 1'b0;
      crc_init <= 1'b0;
      if (stat_rd) st_irq <= 1'b0;
      if (hb_wr) begin
        case (hb_idx)
          2'd0: b0 <= hb_wdata;
          2'd1: b1 <= hb_wdata;
          2'd2: b2 <= hb_wdata;
          default: ;
        endcase
      end
      if (cmd_wr) begin
        tsk <= cmd_code;
        cnt <= '0;
        case (cmd_code)
          T_SFH, T_SFS: begin st <= S_HUNT; st_bfree <= 1'b0; st_err <= 1'b0; end
          T_R3H, T_RSB: begin st <= S_COL;  st_bfree <= 1'b0; st_err <= 1'b0; end
          T_LOAD:       begin st <= S_LOAD; st_bfree <= 1'b0; st_err <= 1'b0; end
          T_RST:        begin st <= S_IDLE; st_bfree <= 1'b1; st_err <= 1'b0; end
          default:      begin st <= S_IDLE; st_bfree <= 1'b1; st_irq <= 1'b1; end
        endcase
      end else begin
        case (st)
          S_HUNT: if (sync_hit) begin
            st_mobile <= sync_mob;
            cnt <= '0;
            if (tsk == T_SFS) begin
              st <= S_IDLE; st_bfree <= 1'b1; st_irq <= 1'b1; crc_init <= 1'b1;
            end else st <= S_COL;
          end
          S_COL: if (rx_vld) begin
            sh  <= {sh[22:0], rx_bit};
            cnt <= cnt + 5'd1;
            if (last_bit) begin
              if (tsk == T_RSB) begin
                b0 <= {sh[6:0], rx_bit};
                st <= S_IDLE; st_bfree <= 1'b1; st_irq <= 1'b1; crc_init <= 1'b1;
              end else st <= S_CHK;
            end
          end
          S_CHK: begin
            st_err <= fh_bad;
            if (tsk == T_SFH) begin
              b0 <= fh_fix[15:8];
              b1 <= fh_fix[7:0];
            end else begin
              b0 <= sh[23:16];
              b1 <= sh[15:8];
              b2 <= sh[7:0];
            end
            st <= S_IDLE; st_bfree <= 1'b1; st_irq <= 1'b1; crc_init <= 1'b1;
          end
          S_LOAD: begin
            pat <= {b0, b1};
            pat_ld <= 1'b1;
            st <= S_IDLE; st_bfree <= 1'b1; st_irq <= 1'b1; crc_init <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

module rx_task_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_wr,
  input logic [2:0] cmd_code,
  input logic       st_bfree,
  input logic       st_irq,
  input logic       sync_srch,
  input logic       pat_ld,
  input logic       crc_init
);
  // R3
  srch_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_srch |-> !st_bfree);
  // R2
  task_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd_code >= 3'd1 && cmd_code <= 3'd5) |=> !st_bfree);
  // R8
  irq_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_irq) |-> st_bfree);
  // R8
  crc_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    crc_init |-> (st_bfree && st_irq));
  // R7
  pat_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pat_ld |=> !pat_ld);
  // R10
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd_code == 3'd7) |=> (!sync_srch && st_bfree));
endmodule

bind rx_task_seq rx_task_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_code(cmd_code),
  .st_bfree(st_bfree), .st_irq(st_irq), .sync_srch(sync_srch),
  .pat_ld(pat_ld), .crc_init(crc_init)
);

// File: tb/rx_task_seq_tb.sv
module rx_task_seq_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_wr = 1'b0, stat_rd = 1'b0, hb_wr = 1'b0;
  logic [2:0] cmd_code = '0;
  logic [1:0] hb_idx = '0;
  logic [7:0] hb_wdata = '0, hb_rdata;
  logic rx_vld = 1'b0, rx_bit = 1'b0, sync_hit = 1'b0, sync_mob = 1'b0, fh_bad = 1'b0;
  logic st_bfree, st_irq, st_err, st_mobile, sync_srch, pat_ld, crc_init;
  logic [15:0] pat, fh_fix;
  logic [23:0] fh_word;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;
  assign fh_fix = fh_word[23:8] ^ 16'h0101;

  rx_task_seq u_dut (.*);

  // {fh_bad, 24-bit stream}
  localparam logic [24:0] VEC [4] = '{25'h0_A5C33C, 25'h1_000000, 25'h0_FFFFFF, 25'h1_813F02};

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cmd(logic [2:0] c);
    cmd_wr = 1'b1; cmd_code = c; @(negedge clk); cmd_wr = 1'b0;
  endtask

  task automatic clr_irq();
    stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0;
  endtask

  task automatic bits(logic [23:0] d, int n, logic gaps);
    for (int i = n - 1; i >= 0; i--) begin
      if (gaps) begin rx_vld = 1'b0; rx_bit = ~d[i]; @(negedge clk); end
      rx_vld = 1'b1; rx_bit = d[i]; @(negedge clk);
    end
    rx_vld = 1'b0;
  endtask

  task automatic hit(logic mob);
    sync_mob = mob; sync_hit = 1'b1; rx_vld = 1'b1; rx_bit = 1'b1;
    @(negedge clk); sync_hit = 1'b0; rx_vld = 1'b0;
  endtask

  task automatic rd(int i, output logic [7:0] v);
    hb_idx = 2'(i); #1 v = hb_rdata;
  endtask

  task automatic hwr(int i, logic [7:0] v);
    hb_wr = 1'b1; hb_idx = 2'(i); hb_wdata = v; @(negedge clk); hb_wr = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    logic [7:0] v0, v1, v2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(0, v0); rd(1, v1); rd(2, v2);
    chk("R1 state", {st_bfree, st_irq, st_err, st_mobile, sync_srch}, 5'b10000);
    chk("R1 pat", pat, 0);
    chk("R1 buf", {v0, v1, v2}, 0);

    foreach (VEC[k]) begin
      // R5 raw read
      fh_bad = VEC[k][24];
      cmd(3'd2);
      chk("R2 bfree cleared", st_bfree, 0);
      bits(VEC[k][23:0], 24, 1'b0);
      @(negedge clk);
      chk("R8 done flags", {st_bfree, st_irq, crc_init}, 3'b111);
      rd(0, v0); rd(1, v1); rd(2, v2);
      chk("R5 raw bytes", {v0, v1, v2}, VEC[k][23:0]);
      chk("R5 err", st_err, VEC[k][24]);
      clr_irq();
      chk("R9 irq cleared", st_irq, 0);
      // R4 frame-head search
      cmd(3'd1);
      @(negedge clk);
      chk("R3 search on", sync_srch, 1);
      hit(k[0]);
      chk("R3 search off after hit", sync_srch, 0);
      bits(VEC[k][23:0], 24, 1'b0);
      @(negedge clk);
      rd(0, v0); rd(1, v1); rd(2, v2);
      chk("R4 fixed bytes", {v0, v1}, VEC[k][23:8] ^ 16'h0101);
      chk("R4 idx2 kept", v2, VEC[k][7:0]);
      chk("R4 err", st_err, VEC[k][24]);
      chk("R4 mobile", st_mobile, k[0]);
      clr_irq();
      // R6 single byte with gaps (R11)
      cmd(3'd4);
      bits({16'h0, VEC[k][15:8]}, 8, 1'b1);
      rd(0, v0);
      chk("R6 R11 byte", v0, VEC[k][15:8]);
      chk("R8 rsb done", {st_bfree, st_irq}, 2'b11);
      clr_irq();
    end

    // R3 sync-only search
    hwr(2, 8'h77);
    cmd(3'd3);
    bits(24'hABCDEF, 24, 1'b0);
    chk("R3 still hunting", {sync_srch, st_irq}, 2'b10);
    hit(1'b1);
    rd(2, v2);
    chk("R3 sfs done", {st_bfree, st_irq, st_mobile, crc_init}, 4'b1111);
    chk("R3 buf untouched", v2, 8'h77);
    clr_irq();

    // R7 sync load
    hwr(0, 8'hA5); hwr(1, 8'h3C);
    cmd(3'd5);
    chk("R7 no search", sync_srch, 0);
    @(negedge clk);
    chk("R7 pattern", pat, 16'hA53C);
    chk("R7 strobe", {pat_ld, st_irq}, 2'b11);
    @(negedge clk);
    chk("R7 strobe one cycle", pat_ld, 0);
    clr_irq();

    // R8 NULL
    cmd(3'd0);
    chk("R8 null done", {st_bfree, st_irq, crc_init}, 3'b110);
    clr_irq();
    cmd(3'd6);
    chk("R2 code6 as null", {st_bfree, st_irq}, 2'b11);
    clr_irq();

    // R10 abort mid read
    hwr(0, 8'h11); hwr(1, 8'h22); hwr(2, 8'h33);
    cmd(3'd2);
    bits(24'h3FF, 10, 1'b0);
    cmd(3'd7);
    chk("R10 abort flags", {st_bfree, st_irq, sync_srch}, 3'b100);
    bits(24'hFFFFFF, 24, 1'b0);
    @(negedge clk);
    rd(0, v0); rd(1, v1); rd(2, v2);
    chk("R10 buffer kept", {v0, v1, v2}, 24'h112233);
    chk("R10 no irq", st_irq, 0);
    cmd(3'd1);
    cmd(3'd7);
    chk("R10 search aborted", sync_srch, 0);

    // R9 set wins over clear
    cmd(3'd4);
    bits(24'h5A >> 1, 7, 1'b0);
    stat_rd = 1'b1;
    bits(24'h0, 1, 1'b0);
    stat_rd = 1'b0;
    rd(0, v0);
    chk("R9 set wins", st_irq, 1);
    chk("R6 byte", v0, 8'h5A);

    summary();
  end
endmodule